// File: doc/BRIEF.md
# Five-Channel Reloading Down-Count Timer

This block holds five independent down-counters behind one small register bus. Each channel has a count buffer that software fills. A separate prescaler supplies a per-channel tick strobe, and a started channel decrements on each tick. When a tick arrives while the count is already zero, the channel expires. It then either reloads from its count buffer or, in one-shot mode, parks at zero. Each expiry sets a status flag, and the flag drives an interrupt line when its enable bit is set. Channels 0 to 3 also have a compare buffer. Each of these four channels drives a PWM level that is high while its count exceeds the compare value, with an optional inversion.

Software controls all five channels through one shared control register. Each channel has a start bit, a manual-update bit, an invert bit and an auto-reload bit, packed into 4-bit groups. The group after channel 0 is left empty. Channel 4 has no invert bit, so its auto-reload bit moves down one place. The live count of every channel can be read back at any time. The counter width is a parameter, 16 or 32 bits.

Top module: `tick_timer_bank`

## Requirements
- R1: Count buffer of channel c is read/write at 0x0C+12c. Compare buffer of channel c<4 is read/write at 0x10+12c. Both keep the low CNT_W bits of a write and read back zero-extended. The two 32-bit configuration words at 0x00 and 0x04 read back exactly what was written.
- R2: Control register at 0x08 maps channel 0 to bits [3:0] and channel c>=1 to bits [4c+7:4c+4]. Within a group: +0 start, +1 manual update, +2 invert, +3 auto-reload. Bits [7:4], bit 23 and bits [31:24] ignore writes and read 0, so an all-ones write reads back 0x007FFF0F.
- R3: While a channel's manual-update bit is 1, its counter is loaded from its count buffer on every clock, whatever the start bit or the tick.
- R4: With start 1 and manual update 0, each tick decrements a non-zero count by exactly one.
- R5: A tick at count zero is an expiry. With auto-reload set, the counter reloads from the count buffer, so expiries repeat every (count buffer + 1) ticks.
- R6: Without auto-reload, an expiry leaves the count at zero. Later ticks cause no further expiry until the next manual update.
- R7: With start and manual update both 0, ticks leave the count unchanged.
- R8: Register 0x44 holds interrupt enables in bits [4:0] and status flags in bits [9:5]. Expiry of channel c sets bit 5+c. Writing 1 to a status bit clears it, and writing 0 leaves it. An expiry in the same cycle as a clear wins.
- R9: irq[c] is high exactly when status bit c and enable bit c are both 1.
- R10: pwm_out[c] (c<4) is high when count > compare buffer, inverted when the invert bit is 1.
- R11: The live count is readable at 0x14+12c for c<4 and at 0x40 for channel 4. Writes to these addresses change nothing.
- R12: Channel 4 has start at bit 20, manual update at bit 21 and auto-reload at bit 22.
- R13: A tick on one channel does not change any other channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when 1 together with bus_sel |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick | input | 5 | Per-channel single-cycle count strobes |
| irq | output | 5 | Per-channel interrupt levels |
| pwm_out | output | 4 | PWM levels of channels 0 to 3 |

## Verification
The assertions assume that tick and the bus inputs carry known values on every clock after reset. They also assume that a buffer being loaded by manual update holds its value across the loading edge, which a compare against the previous cycle needs. The bench meets this by changing inputs only on falling edges. It drives each tick as a pulse one clock wide and writes one register per access, so control, buffer and tick changes never share an edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NUM_CH  = 5;
  localparam int NUM_PWM = NUM_CH - 1;
  localparam int CTL_W   = 4 * (NUM_CH + 1);
  localparam int INT_W   = 2 * NUM_CH;

  typedef struct packed {
    logic start;
    logic manual;
    logic invert;
    logic reload;
  } tmr_ctl_t;

  localparam int A_CFG0 = 'h00;
  localparam int A_CFG1 = 'h04;
  localparam int A_CTL  = 'h08;
  localparam int A_INT  = 'h44;

  function automatic int cntb_addr(int c);
    return 'h0C + 12 * c;
  endfunction

  function automatic int cmpb_addr(int c);
    return 'h10 + 12 * c;
  endfunction

  function automatic int obs_addr(int c);
    return (c == NUM_CH - 1) ? 'h40 : 'h14 + 12 * c;
  endfunction

  // group 1 of the control word is skipped after channel 0
  function automatic int ctl_base(int c);
    return (c == 0) ? 0 : 4 * (c + 1);
  endfunction

  function automatic int reload_pos(int c);
    return ctl_base(c) + ((c == NUM_CH - 1) ? 2 : 3);
  endfunction

  function automatic logic [CTL_W-1:0] ctl_impl_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[ctl_base(c)]     = 1'b1;
      m[ctl_base(c) + 1] = 1'b1;
      if (c < NUM_PWM) m[ctl_base(c) + 2] = 1'b1;
      m[reload_pos(c)]   = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_PWM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_ctl_t         ctl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             pwm
);

  logic [CNT_W-1:0] cnt_d;
  logic             spent_q, spent_d;
  logic             cnt_en;

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    spent_d = spent_q;
    expire  = 1'b0;
    if (ctl.manual) begin
      cnt_d   = cnt_buf;
      spent_d = 1'b0;
    end else if (ctl.start && tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (!spent_q) begin
        expire = 1'b1;
        if (ctl.reload) cnt_d   = cnt_buf;
        else            spent_d = 1'b1;
      end
    end
  end

  assign cnt_en = ctl.manual | (ctl.start & tick);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      spent_q <= spent_d;
    end
  end

  generate
    if (HAS_PWM) begin : g_pwm
      assign pwm = (cnt_q > cmp_buf) ^ ctl.invert;
    end else begin : g_nopwm
      logic unused_pwm_in;
      assign unused_pwm_in = ^{cmp_buf, ctl.invert};
      assign pwm = 1'b0;
    end
  endgenerate

  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.manual |=> cnt_q == $past(cnt_buf)); // R3

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.manual && ctl.start && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4

  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.reload) |=> cnt_q == $past(cnt_buf)); // R5

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl.reload) |=> (cnt_q == '0 && !expire)); // R6

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.manual && !ctl.start) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*N-1:0] wdata,
  input  logic [N-1:0]   expire,
  output logic [N-1:0]   en_q,
  output logic [N-1:0]   stat_q,
  output logic [N-1:0]   irq
);

  logic [N-1:0] en_d, stat_d, clr_mask;
  logic         reg_en;

  always_comb begin
    clr_mask = wr_en ? wdata[N +: N] : '0;
    en_d     = wr_en ? wdata[N-1:0] : en_q;
    stat_d   = (stat_q & ~clr_mask) | expire;
  end

  assign reg_en = wr_en | (|expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else if (reg_en) begin
      en_q   <= en_d;
      stat_q <= stat_d;
    end
  end

  assign irq = stat_q & en_q;

  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((stat_q & $past(expire)) == $past(expire))); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((stat_q & $past(wdata[N +: N] & ~expire)) == '0)); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_PWM-1:0] pwm_out
);

  localparam logic [CTL_W-1:0] CTL_MASK = ctl_impl_mask();

  logic              rst_n_s;
  logic              wr;
  logic [31:0]       cfg0_q, cfg1_q;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              cfg0_en, cfg1_en, ctl_en, int_en;
  logic [CNT_W-1:0]  cntb_all [NUM_CH];
  logic [CNT_W-1:0]  cmpb_all [NUM_CH];
  logic [CNT_W-1:0]  cnt_all  [NUM_CH];
  logic [NUM_CH-1:0] expire_all, pwm_all, en_q, stat_q;
  logic              unused_pwm_top;

  tmr_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign wr      = bus_sel & bus_we;
  assign cfg0_en = wr && (bus_addr == ADDR_W'(A_CFG0));
  assign cfg1_en = wr && (bus_addr == ADDR_W'(A_CFG1));
  assign ctl_en  = wr && (bus_addr == ADDR_W'(A_CTL));
  assign int_en  = wr && (bus_addr == ADDR_W'(A_INT));
  assign ctl_d   = bus_wdata[CTL_W-1:0] & CTL_MASK;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg0_q <= '0;
    else if (cfg0_en) cfg0_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg1_q <= '0;
    else if (cfg1_en) cfg1_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int B  = ctl_base(c);
      localparam bit HP = (c < NUM_PWM);

      tmr_ctl_t          cc;
      logic              cntb_en;
      logic [CNT_W-1:0]  cntb_q, cmp_loc;

      assign cc.start  = ctl_q[B];
      assign cc.manual = ctl_q[B+1];
      assign cc.invert = HP ? ctl_q[B+2] : 1'b0;
      assign cc.reload = ctl_q[reload_pos(c)];

      assign cntb_en = wr && (bus_addr == ADDR_W'(cntb_addr(c)));

      always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s) cntb_q <= '0;
        else if (cntb_en) cntb_q <= bus_wdata[CNT_W-1:0];
      end

      if (HP) begin : g_cmp
        logic cmpb_en;
        logic [CNT_W-1:0] cmpb_q;
        assign cmpb_en = wr && (bus_addr == ADDR_W'(cmpb_addr(c)));
        always_ff @(posedge clk or negedge rst_n_s) begin
          if (!rst_n_s) cmpb_q <= '0;
          else if (cmpb_en) cmpb_q <= bus_wdata[CNT_W-1:0];
        end
        assign cmp_loc = cmpb_q;
      end else begin : g_nocmp
        assign cmp_loc = '0;
      end

      assign cntb_all[c] = cntb_q;
      assign cmpb_all[c] = cmp_loc;

      tmr_chan #(
        .CNT_W   (CNT_W),
        .HAS_PWM (HP)
      ) i_chan (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .tick    (tick[c]),
        .ctl     (cc),
        .cnt_buf (cntb_q),
        .cmp_buf (cmp_loc),
        .cnt_q   (cnt_all[c]),
        .expire  (expire_all[c]),
        .pwm     (pwm_all[c])
      );
    end
  endgenerate

  tmr_irq #(.N(NUM_CH)) i_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (int_en),
    .wdata  (bus_wdata[INT_W-1:0]),
    .expire (expire_all),
    .en_q   (en_q),
    .stat_q (stat_q),
    .irq    (irq)
  );

  assign pwm_out        = pwm_all[NUM_PWM-1:0];
  assign unused_pwm_top = pwm_all[NUM_CH-1];

  // read decode
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CFG0)) bus_rdata = cfg0_q;
    if (bus_addr == ADDR_W'(A_CFG1)) bus_rdata = cfg1_q;
    if (bus_addr == ADDR_W'(A_CTL))  bus_rdata = 32'(ctl_q);
    if (bus_addr == ADDR_W'(A_INT))  bus_rdata = 32'({stat_q, en_q});
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(cntb_addr(c))) bus_rdata = 32'(cntb_all[c]);
      if (c < NUM_PWM && bus_addr == ADDR_W'(cmpb_addr(c))) bus_rdata = 32'(cmpb_all[c]);
      if (bus_addr == ADDR_W'(obs_addr(c))) bus_rdata = 32'(cnt_all[c]);
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq[0]) |-> stat_q[0] && en_q[0]); // R9

endmodule

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;

  localparam int CW = 16;

  logic        clk, rst_n, bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0]  tick, irq;
  logic [3:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] rv;
  logic [15:0] exp_cnt [5];

  tick_timer_bank #(.CNT_W(CW), .ADDR_W(8)) i_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq(irq), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int a_cntb(int c); return 'h0C + 12 * c; endfunction
  function automatic int a_cmpb(int c); return 'h10 + 12 * c; endfunction
  function automatic int a_obs(int c);  return (c == 4) ? 'h40 : 'h14 + 12 * c; endfunction

  function automatic logic [31:0] cbits(int c, bit st, bit mu, bit iv, bit ar);
    int b;
    logic [31:0] r;
    b = (c == 0) ? 0 : 4 * (c + 1);
    r = '0;
    r[b] = st;
    r[b+1] = mu;
    if (c < 4) r[b+2] = iv;
    r[(c == 4) ? b + 2 : b + 3] = ar;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_sel = 1'b1; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic tk(logic [4:0] m);
    @(negedge clk);
    tick = m;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; tick = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd('h08, rv); chk("R2 reset ctl", rv, 0);
    rd('h44, rv); chk("R8 reset int", rv, 0);
    for (int c = 0; c < 5; c++) begin
      rd(a_obs(c), rv); chk("R11 reset count", rv, 0);
    end
    chk("R9 reset irq", 32'(irq), 0);
    chk("R10 reset pwm", 32'(pwm_out), 0);

    // R1 buffers and config words
    for (int c = 0; c < 5; c++) begin
      exp_cnt[c] = 16'(c * 'h111 + 7);
      wr(a_cntb(c), 32'hA5A50000 | 32'(exp_cnt[c]));
      rd(a_cntb(c), rv); chk("R1 count buffer", rv, 32'(exp_cnt[c]));
      if (c < 4) begin
        wr(a_cmpb(c), 32'h5A5A0000 | 32'(c + 'h40));
        rd(a_cmpb(c), rv); chk("R1 compare buffer", rv, 32'(c + 'h40));
      end
    end
    wr('h00, 32'hDEADBEEF); rd('h00, rv); chk("R1 config0", rv, 32'hDEADBEEF);
    wr('h04, 32'h12345678); rd('h04, rv); chk("R1 config1", rv, 32'h12345678);

    // R2 layout: all ones, also loads every counter through manual update
    wr('h08, 32'hFFFFFFFF); rd('h08, rv); chk("R2 ctl mask", rv, 32'h007FFF0F);
    wr('h08, 0);
    for (int c = 0; c < 5; c++) begin
      rd(a_obs(c), rv); chk("R3 manual load", rv, 32'(exp_cnt[c]));
    end
    wr('h14, 0); wr('h40, 0);
    rd('h14, rv); chk("R11 obs write ignored ch0", rv, 32'(exp_cnt[0]));
    rd('h40, rv); chk("R11 obs write ignored ch4", rv, 32'(exp_cnt[4]));

    // one-shot countdown on every channel
    for (int c = 0; c < 5; c++) begin
      int n = 3 + c;
      wr(a_cntb(c), n);
      wr('h08, cbits(c, 0, 1, 0, 0));
      wr('h08, cbits(c, 1, 0, 0, 0));
      wr('h44, 32'h3E0);
      exp_cnt[c] = 16'(n);
      for (int k = 1; k <= n; k++) begin
        tk(5'(1 << c));
        rd(a_obs(c), rv); chk("R4 decrement", rv, 32'(n - k));
      end
      rd(a_obs((c + 1) % 5), rv); chk("R13 other channel", rv, 32'(exp_cnt[(c + 1) % 5]));
      rd('h44, rv); chk("R8 no early flag", rv, 0);
      tk(5'(1 << c));
      rd('h44, rv); chk("R8 expiry flag", rv, 32'(1 << (5 + c)));
      chk("R9 irq masked", 32'(irq), 0);
      rd(a_obs(c), rv); chk("R6 parked at zero", rv, 0);
      wr('h44, 32'(1 << (5 + c)));
      tk(5'(1 << c));
      rd('h44, rv); chk("R6 single expiry", rv, 0);
      exp_cnt[c] = 0;
    end

    // auto-reload, period N+1
    for (int c = 0; c < 5; c++) begin
      wr(a_cntb(c), 2);
      wr('h08, cbits(c, 0, 1, 0, 1));
      wr('h08, cbits(c, 1, 0, 0, 1));
      wr('h44, 32'(1 << c));
      for (int p = 0; p < 3; p++) begin
        tk(5'(1 << c)); tk(5'(1 << c));
        rd(a_obs(c), rv); chk("R5 at zero", rv, 0);
        chk("R9 idle irq", 32'(irq), 0);
        tk(5'(1 << c));
        rd(a_obs(c), rv);
        chk((c == 4) ? "R12 ch4 reload" : "R5 reload", rv, 2);
        chk("R9 irq raised", 32'(irq), 32'(1 << c));
        wr('h44, 32'((1 << c) | (1 << (5 + c))));
        chk("R8 cleared irq", 32'(irq), 0);
      end
    end

    // R7 freeze
    wr(a_cntb(0), 9);
    wr('h08, cbits(0, 0, 1, 0, 0));
    wr('h08, cbits(0, 1, 0, 0, 0));
    tk(5'b00001); tk(5'b00001);
    wr('h08, 0);
    tk(5'b00001); tk(5'b00001); tk(5'b11111);
    rd('h14, rv); chk("R7 frozen", rv, 7);

    // R8 partial clear, R9 enable gating
    wr(a_cntb(0), 0); wr(a_cntb(1), 0);
    wr('h08, cbits(0, 0, 1, 0, 0) | cbits(1, 0, 1, 0, 0));
    wr('h08, cbits(0, 1, 0, 0, 0) | cbits(1, 1, 0, 0, 0));
    wr('h44, 32'h3E0);
    tk(5'b00011);
    rd('h44, rv); chk("R8 two flags", rv, 32'h060);
    wr('h44, 32'h022);
    rd('h44, rv); chk("R8 partial clear", rv, 32'h042);
    chk("R9 enabled channel only", 32'(irq), 32'b00010);
    wr('h44, 32'h3E0);

    // R10 PWM sweep with and without inversion
    for (int c = 0; c < 4; c++) begin
      for (int inv = 0; inv < 2; inv++) begin
        wr(a_cmpb(c), 3);
        wr(a_cntb(c), 6);
        wr('h08, cbits(c, 0, 1, inv[0], 0));
        wr('h08, cbits(c, 1, 0, inv[0], 0));
        for (int v = 6; v >= 0; v--) begin
          @(negedge clk);
          chk("R10 pwm level", 32'(pwm_out[c]), 32'((v > 3) ^ inv[0]));
          if (v > 0) tk(5'(1 << c));
        end
      end
    end

    done = 1;
    finish_run();
  end

endmodule